// File: doc/BRIEF.md
# Dual Alarm Monitor for Sampled Sensor Words

This block watches a stream of sampled sensor words and raises up to two alarms. On each cycle where `sample_stb` is high, each alarm reads one of three sources: the rate word, the temperature word or a status word. It then tests either that value itself (level mode) or how far the value has moved over a programmed number of samples (change mode). The test is against its own signed 16-bit threshold, in a direction of its own choosing. A single control word sets both alarms and the pin output.

The two results are held as flags until the next strobe. Their OR drives one of two output pins, with a selectable active level. The pin that is not selected rests at the inactive level. Change mode keeps a private circular history for each alarm. A change alarm stays quiet until that history holds enough samples taken from the current source.

Top module: `dual_alarm_monitor`

## Requirements
- R1: The source code for alarm 1 is in `ctrl[11:8]` and the code for alarm 2 is in `ctrl[15:12]`. Code 1 selects the rate word, code 2 the temperature word and code 3 the status word. Code 0 and codes 4 to 15 disable the alarm, and a disabled alarm's flag is 0 after the next strobe.
- R2: In level mode (`ctrl[6]` = 0 for alarm 1, `ctrl[7]` = 0 for alarm 2), the sample is compared with the threshold as a signed two's complement number. The comparison is strict. Polarity bit `ctrl[4]` (alarm 1) or `ctrl[5]` (alarm 2) set to 1 trips on value > threshold, and set to 0 trips on value < threshold.
- R3: In change mode (`ctrl[6]`/`ctrl[7]` = 1), the compared value is the current sample minus the sample taken N strobes earlier. This difference is computed one bit wider than the data so that it never wraps, and it uses the same signed, strict polarity rule as R2.
- R4: The span N comes from `span1`/`span2`. The values 0 and 1 both mean one strobe back.
- R5: A change-mode alarm cannot trip until it has stored at least N samples since it was last enabled or its source selection changed. A source change takes effect on the strobe that carries it.
- R6: `ctrl[3]` = 1 makes the rate source use `rate_filt` instead of `rate_raw`. This bit has no effect on the temperature or status sources.
- R7: The flags change only on strobe cycles and are visible in the cycle after the strobe. `alarm_flags[0]` is alarm 1 (status bit 8 position) and `alarm_flags[1]` is alarm 2 (status bit 9 position).
- R8: The pin indicator is the OR of both flags. `ctrl[2]` enables the output, `ctrl[1]` = 1 makes it active high, and `ctrl[0]` = 1 routes it to `alarm_pin2` (0 routes it to `alarm_pin1`). An unselected or disabled pin holds the inactive level, which is the inverse of `ctrl[1]`. The pins follow the flags and `ctrl` without added delay.
- R9: Reset clears both flags and empties both histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | One-cycle strobe marking a new sample set |
| ctrl | input | 16 | Alarm and pin configuration word |
| thresh1 | input | 16 | Signed threshold for alarm 1 |
| thresh2 | input | 16 | Signed threshold for alarm 2 |
| span1 | input | 8 | Change-mode span for alarm 1 |
| span2 | input | 8 | Change-mode span for alarm 2 |
| rate_raw | input | 16 | Unfiltered rate word |
| rate_filt | input | 16 | Filtered rate word |
| temp_in | input | 16 | Temperature word |
| status_in | input | 16 | Status word |
| alarm_flags | output | 2 | Alarm flags, bit 0 = alarm 1, bit 1 = alarm 2 |
| alarm_pin1 | output | 1 | Indicator output pin 1 |
| alarm_pin2 | output | 1 | Indicator output pin 2 |

## Verification
Two events can fall on the same strobe: one alarm in level mode tripping, and the other alarm in change mode completing its first valid difference. The bench sets up that coincidence by giving alarm 2 a span-1 change history on the status word while alarm 1 watches temperature at level. It then moves both sources past their thresholds on a single strobe. The result is judged by both flag bits rising together and by the routed pin reaching its active level in the same cycle.

// File: rtl/alm_pkg.sv
package alm_pkg;

   typedef enum logic [3:0] {
      SRC_OFF  = 4'd0,
      SRC_RATE = 4'd1,
      SRC_TEMP = 4'd2,
      SRC_STAT = 4'd3
   } alm_src_e;

   localparam int unsigned NUM_ALARMS = 2;
   localparam int unsigned SRC_CODE_W = 4;

   // bit positions inside the control word
   localparam int unsigned CTL_SEL    = 0;
   localparam int unsigned CTL_POL    = 1;
   localparam int unsigned CTL_OE     = 2;
   localparam int unsigned CTL_FILT   = 3;
   localparam int unsigned CTL_GT0    = 4;
   localparam int unsigned CTL_DYN0   = 6;
   localparam int unsigned CTL_SRC0   = 8;

   function automatic logic src_is_live(input logic [SRC_CODE_W-1:0] code);
      return (code == SRC_RATE) || (code == SRC_TEMP) || (code == SRC_STAT);
   endfunction

endpackage

// File: rtl/alm_src_sel.sv
module alm_src_sel
   import alm_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [SRC_CODE_W-1:0] code,
   input  logic                  use_filt,
   input  logic [DATA_W-1:0]     rate_raw,
   input  logic [DATA_W-1:0]     rate_filt,
   input  logic [DATA_W-1:0]     temp_in,
   input  logic [DATA_W-1:0]     status_in,
   output logic [DATA_W-1:0]     sample,
   output logic                  live,
   output logic                  filt_eff
);

   always_comb begin
      sample   = '0;
      filt_eff = 1'b0;
      unique case (code)
         SRC_RATE: begin
            sample   = use_filt ? rate_filt : rate_raw;
            filt_eff = use_filt;
         end
         SRC_TEMP: sample = temp_in;
         SRC_STAT: sample = status_in;
         default:  sample = '0;
      endcase
   end

   assign live = src_is_live(code);

endmodule

// File: rtl/alm_channel.sv
module alm_channel #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SPAN_W = 8,
   parameter int unsigned KEY_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              live,
   input  logic              dyn,
   input  logic              gt,
   input  logic [KEY_W-1:0]  key,
   input  logic [SPAN_W-1:0] span,
   input  logic [DATA_W-1:0] thr,
   input  logic [DATA_W-1:0] smp,
   output logic              flag
);

   localparam int unsigned DEPTH = 1 << SPAN_W;
   localparam int unsigned CNT_W = SPAN_W + 1;
   localparam int unsigned VAL_W = DATA_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [DATA_W-1:0] hist [DEPTH];
   logic [SPAN_W-1:0] wp;
   logic [CNT_W-1:0]  fill;
   logic [KEY_W-1:0]  key_q;
   logic              live_q;

   logic [SPAN_W-1:0] span_eff;
   logic              fresh;
   logic              have;
   logic [DATA_W-1:0] past;
   logic signed [VAL_W-1:0] cur_v, past_v, thr_v, diff_v, val_v;
   logic              hit;
   logic              flag_d;

   assign span_eff = (span == '0) ? SPAN_W'(1) : span;
   assign fresh    = !live_q || (key != key_q);
   assign have     = !fresh && (fill >= {1'b0, span_eff});
   assign past     = hist[wp - span_eff];

   assign cur_v  = signed'({smp[DATA_W-1], smp});
   assign past_v = signed'({past[DATA_W-1], past});
   assign thr_v  = signed'({thr[DATA_W-1], thr});
   assign diff_v = cur_v - past_v;
   assign val_v  = dyn ? diff_v : cur_v;
   assign hit    = gt ? (val_v > thr_v) : (val_v < thr_v);
   assign flag_d = live && hit && (!dyn || have);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         wp     <= '0;
         fill   <= '0;
         key_q  <= '0;
         live_q <= 1'b0;
      end else if (stb) begin
         flag   <= flag_d;
         live_q <= live;
         key_q  <= key;
         if (!live) begin
            fill <= '0;
         end else begin
            wp <= wp + SPAN_W'(1);
            if (fresh)
               fill <= CNT_W'(1);
            else if (fill != CNT_MAX)
               fill <= fill + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (stb && live)
         hist[wp] <= smp;
   end

endmodule

// File: rtl/alm_pin_drv.sv
module alm_pin_drv #(
   parameter int unsigned N_FLAGS = 2,
   parameter bit          PIN_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] flags,
   input  logic               out_en,
   input  logic               act_high,
   input  logic               route_b,
   output logic               pin_a,
   output logic               pin_b
);

   logic ind, a_on, b_on, a_lvl, b_lvl;

   assign ind   = |flags;
   assign a_on  = out_en && ind && !route_b;
   assign b_on  = out_en && ind &&  route_b;
   assign a_lvl = ~(a_on ^ act_high);
   assign b_lvl = ~(b_on ^ act_high);

   if (PIN_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_a <= 1'b0;
            pin_b <= 1'b0;
         end else begin
            pin_a <= a_lvl;
            pin_b <= b_lvl;
         end
      end
   end else begin : g_comb
      assign pin_a = a_lvl;
      assign pin_b = b_lvl;
   end

endmodule

// File: rtl/dual_alarm_monitor.sv
module dual_alarm_monitor
   import alm_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned SPAN_W  = 8,
   parameter bit          PIN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic [15:0]       ctrl,
   input  logic [DATA_W-1:0] thresh1,
   input  logic [DATA_W-1:0] thresh2,
   input  logic [SPAN_W-1:0] span1,
   input  logic [SPAN_W-1:0] span2,
   input  logic [DATA_W-1:0] rate_raw,
   input  logic [DATA_W-1:0] rate_filt,
   input  logic [DATA_W-1:0] temp_in,
   input  logic [DATA_W-1:0] status_in,
   output logic [1:0]        alarm_flags,
   output logic              alarm_pin1,
   output logic              alarm_pin2
);

   localparam int unsigned KEY_W = SRC_CODE_W + 1;

   if (DATA_W < 2) begin : g_bad_data
      $error("dual_alarm_monitor: DATA_W must be at least 2");
   end
   if (SPAN_W < 1 || SPAN_W > 12) begin : g_bad_span
      $error("dual_alarm_monitor: SPAN_W must lie in 1..12");
   end

   logic [DATA_W-1:0] thr_arr  [NUM_ALARMS];
   logic [SPAN_W-1:0] span_arr [NUM_ALARMS];

   assign thr_arr[0]  = thresh1;
   assign thr_arr[1]  = thresh2;
   assign span_arr[0] = span1;
   assign span_arr[1] = span2;

   for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alm
      logic [SRC_CODE_W-1:0] code;
      logic [DATA_W-1:0]     smp;
      logic                  live;
      logic                  filt_eff;

      assign code = ctrl[CTL_SRC0 + SRC_CODE_W*g +: SRC_CODE_W];

      alm_src_sel #(.DATA_W(DATA_W)) u_sel (
         .code      (code),
         .use_filt  (ctrl[CTL_FILT]),
         .rate_raw  (rate_raw),
         .rate_filt (rate_filt),
         .temp_in   (temp_in),
         .status_in (status_in),
         .sample    (smp),
         .live      (live),
         .filt_eff  (filt_eff)
      );

      alm_channel #(.DATA_W(DATA_W), .SPAN_W(SPAN_W), .KEY_W(KEY_W)) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .stb   (sample_stb),
         .live  (live),
         .dyn   (ctrl[CTL_DYN0 + g]),
         .gt    (ctrl[CTL_GT0 + g]),
         .key   ({filt_eff, code}),
         .span  (span_arr[g]),
         .thr   (thr_arr[g]),
         .smp   (smp),
         .flag  (alarm_flags[g])
      );
   end

   alm_pin_drv #(.N_FLAGS(NUM_ALARMS), .PIN_REG(PIN_REG)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (alarm_flags),
      .out_en   (ctrl[CTL_OE]),
      .act_high (ctrl[CTL_POL]),
      .route_b  (ctrl[CTL_SEL]),
      .pin_a    (alarm_pin1),
      .pin_b    (alarm_pin2)
   );

endmodule

// File: rtl/alm_monitor_chk.sv
module alm_monitor_chk #(
   parameter bit PIN_REG = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        sample_stb,
   input logic [15:0] ctrl,
   input logic [1:0]  alarm_flags,
   input logic        alarm_pin1,
   input logic        alarm_pin2
);

   // R7: flags move only on strobe cycles
   a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> $stable(alarm_flags));

   // R1: code 0 disables alarm 1 / alarm 2
   a_r1_off_alm1: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && ctrl[11:8] == 4'd0) |=> !alarm_flags[0]);

   a_r1_off_alm2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && ctrl[15:12] == 4'd0) |=> !alarm_flags[1]);

   if (!PIN_REG) begin : g_pin_chk
      // R8: output disabled leaves both pins inactive
      a_r8_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl[2] |-> (alarm_pin1 == !ctrl[1]) && (alarm_pin2 == !ctrl[1]));

      // R8: at most one pin active at a time
      a_r8_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
         $countones({alarm_pin1 == ctrl[1], alarm_pin2 == ctrl[1]}) <= 1);

      // R8: any flag drives the routed pin active
      a_r8_routed: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl[2] && (|alarm_flags)) |->
            ((ctrl[0] ? alarm_pin2 : alarm_pin1) == ctrl[1]));
   end

endmodule

bind dual_alarm_monitor alm_monitor_chk #(.PIN_REG(PIN_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sample_stb  (sample_stb),
   .ctrl        (ctrl),
   .alarm_flags (alarm_flags),
   .alarm_pin1  (alarm_pin1),
   .alarm_pin2  (alarm_pin2)
);

// File: tb/dual_alarm_monitor_tb.sv
module dual_alarm_monitor_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_stb = 1'b0;
   logic [15:0] ctrl = '0;
   logic [15:0] thresh1 = '0, thresh2 = '0;
   logic [7:0]  span1 = '0, span2 = '0;
   logic [15:0] rate_raw = '0, rate_filt = '0, temp_in = '0, status_in = '0;
   logic [1:0]  alarm_flags;
   logic        alarm_pin1, alarm_pin2;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dual_alarm_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .ctrl(ctrl),
      .thresh1(thresh1), .thresh2(thresh2), .span1(span1), .span2(span2),
      .rate_raw(rate_raw), .rate_filt(rate_filt), .temp_in(temp_in),
      .status_in(status_in), .alarm_flags(alarm_flags),
      .alarm_pin1(alarm_pin1), .alarm_pin2(alarm_pin2)
   );

   // {src2, src1, dyn2, dyn1, gt2, gt1, filt, oe, pol, sel}
   function automatic logic [15:0] mk(input logic [3:0] s2, input logic [3:0] s1,
                                      input logic d2, input logic d1,
                                      input logic g2, input logic g1,
                                      input logic f, input logic oe,
                                      input logic pol, input logic sel);
      return {s2, s1, d2, d1, g2, g1, f, oe, pol, sel};
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one strobe; returns at the next falling edge with flags updated
   task automatic strobe();
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 flags after reset", 16'(alarm_flags), 16'h0);
      chk("R8 pin1 idle at reset cfg", 16'(alarm_pin1), 16'h1);
      chk("R8 pin2 idle at reset cfg", 16'(alarm_pin2), 16'h1);
   endtask

   task automatic t_static();
      ctrl = mk(4'd3, 4'd2, 0, 0, 1, 1, 0, 0, 0, 0);
      thresh1 = 16'd100; temp_in = 16'd101;
      thresh2 = 16'h0010; status_in = 16'h8000;
      strobe();
      chk("R2 temp above thr, status negative", 16'(alarm_flags), 16'h1);
      temp_in = 16'd100;
      strobe();
      chk("R2 strict compare at equal", 16'(alarm_flags), 16'h0);
      ctrl = mk(4'd3, 4'd2, 0, 0, 1, 0, 0, 0, 0, 0);
      thresh1 = 16'hFFFC; temp_in = 16'hFFFB; status_in = 16'd17;
      strobe();
      chk("R2 signed less-than and status gt", 16'(alarm_flags), 16'h3);
   endtask

   task automatic t_disable();
      ctrl = mk(4'd7, 4'd0, 0, 0, 1, 1, 0, 0, 0, 0);
      thresh1 = 16'd0; temp_in = 16'd1000; status_in = 16'h7000; thresh2 = 16'd0;
      strobe();
      chk("R1 code 0 and code 7 disable", 16'(alarm_flags), 16'h0);
   endtask

   task automatic t_hold();
      ctrl = mk(4'd0, 4'd2, 0, 0, 0, 1, 0, 0, 0, 0);
      thresh1 = 16'd0; temp_in = 16'd5;
      strobe();
      chk("R7 flag set on strobe", 16'(alarm_flags), 16'h1);
      temp_in = 16'hFFFB;
      repeat (5) @(negedge clk);
      chk("R7 flag held without strobe", 16'(alarm_flags), 16'h1);
      strobe();
      chk("R7 flag cleared on next strobe", 16'(alarm_flags), 16'h0);
   endtask

   task automatic t_filter();
      thresh1 = 16'd50; thresh2 = 16'd50;
      rate_raw = 16'd10; rate_filt = 16'd60; temp_in = 16'd0;
      ctrl = mk(4'd2, 4'd1, 0, 0, 1, 1, 0, 0, 0, 0);
      strobe();
      chk("R6 raw rate used", 16'(alarm_flags), 16'h0);
      ctrl = mk(4'd2, 4'd1, 0, 0, 1, 1, 1, 0, 0, 0);
      strobe();
      chk("R6 filtered rate only on rate source", 16'(alarm_flags), 16'h1);
   endtask

   task automatic t_dynamic();
      ctrl = mk(4'd0, 4'd0, 0, 0, 0, 0, 0, 0, 0, 0);
      strobe();
      ctrl = mk(4'd0, 4'd2, 0, 1, 0, 1, 0, 0, 0, 0);
      thresh1 = 16'd10; span1 = 8'd3;
      temp_in = 16'd0;   strobe(); chk("R5 first sample no trip", 16'(alarm_flags), 16'h0);
      temp_in = 16'd100; strobe(); chk("R5 history short (1)", 16'(alarm_flags), 16'h0);
      temp_in = 16'd200; strobe(); chk("R5 history short (2)", 16'(alarm_flags), 16'h0);
      temp_in = 16'd300; strobe(); chk("R3 change over 3 samples", 16'(alarm_flags), 16'h1);
      span1 = 8'd1;
      temp_in = 16'h8000; strobe(); chk("R3 negative change", 16'(alarm_flags), 16'h0);
      temp_in = 16'h7FFF; strobe(); chk("R3 wide difference no wrap", 16'(alarm_flags), 16'h1);
      span1 = 8'd0;
      temp_in = 16'd5;  strobe(); chk("R4 span 0 negative step", 16'(alarm_flags), 16'h0);
      temp_in = 16'd30; strobe(); chk("R4 span 0 acts as 1", 16'(alarm_flags), 16'h1);
      temp_in = 16'd30; strobe(); chk("R4 span 0 zero change", 16'(alarm_flags), 16'h0);
      ctrl = mk(4'd0, 4'd2, 0, 1, 0, 0, 0, 0, 0, 0);
      span1 = 8'd1; thresh1 = 16'hFFCE;
      temp_in = 16'd0;    strobe(); chk("R3 lt change above thr", 16'(alarm_flags), 16'h0);
      temp_in = 16'hFF9C; strobe(); chk("R3 lt change below thr", 16'(alarm_flags), 16'h1);
      ctrl = mk(4'd0, 4'd3, 0, 1, 0, 1, 0, 0, 0, 0);
      thresh1 = 16'd20;
      status_in = 16'd1000; strobe(); chk("R5 source change restarts history", 16'(alarm_flags), 16'h0);
      status_in = 16'd2000; strobe(); chk("R5 new history usable", 16'(alarm_flags), 16'h1);
   endtask

   task automatic t_pins();
      ctrl = mk(4'd0, 4'd2, 0, 0, 0, 1, 0, 1, 1, 0);
      thresh1 = 16'd0; temp_in = 16'd5;
      strobe();
      chk("R8 active high pin1", 16'({alarm_pin2, alarm_pin1}), 16'h1);
      ctrl = mk(4'd0, 4'd2, 0, 0, 0, 1, 0, 1, 0, 1);
      #2;
      chk("R8 active low pin2", 16'({alarm_pin2, alarm_pin1}), 16'h1);
      ctrl = mk(4'd0, 4'd2, 0, 0, 0, 1, 0, 0, 1, 0);
      #2;
      chk("R8 output disabled", 16'({alarm_pin2, alarm_pin1}), 16'h0);
      ctrl = mk(4'd3, 4'd0, 0, 0, 1, 1, 0, 1, 1, 1);
      thresh2 = 16'd0; status_in = 16'd9;
      strobe();
      chk("R8 alarm 2 alone drives OR", 16'({alarm_pin2, alarm_pin1}), 16'h2);
      ctrl = mk(4'd0, 4'd0, 0, 0, 1, 1, 0, 1, 1, 0);
      strobe();
      chk("R8 no flag idle level", 16'({alarm_pin2, alarm_pin1}), 16'h0);
   endtask

   task automatic t_coincide();
      ctrl = mk(4'd3, 4'd2, 1, 0, 1, 1, 0, 1, 1, 1);
      thresh1 = 16'd0; thresh2 = 16'd50; span2 = 8'd1;
      temp_in = 16'hFFFF; status_in = 16'd0;
      strobe();
      chk("R7 both quiet before coincidence", 16'(alarm_flags), 16'h0);
      temp_in = 16'd5; status_in = 16'd100;
      strobe();
      chk("R7 level and change trip together", 16'(alarm_flags), 16'h3);
      chk("R8 routed pin on coincidence", 16'({alarm_pin2, alarm_pin1}), 16'h2);
   endtask

   task automatic t_reset_mid();
      @(negedge clk) rst_n = 1'b0;
      #2;
      chk("R9 flags cleared by reset", 16'(alarm_flags), 16'h0);
      @(negedge clk) rst_n = 1'b1;
      status_in = 16'd5000; temp_in = 16'd5;
      strobe();
      chk("R9 history empty after reset", 16'(alarm_flags), 16'h1);
   endtask

   initial begin
      #100000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_static();
      t_disable();
      t_hold();
      t_filter();
      t_dynamic();
      t_pins();
      t_coincide();
      t_reset_mid();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule